// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block gives an 8-bit microprocessor bus a steady timer tick with a level-held interrupt. A free-running prescaler turns the system clock into a reference strobe. By default it divides 7.3728 MHz by 1024, which gives 7200 Hz. A reloadable down-counter then turns that strobe into the tick, and the default reload of 144 gives 50 Hz. Each tick advances a free-running 8-bit tick count and sets a sticky pending flag. The pending flag drives the active-low interrupt request.

Software reads the tick count to learn whether a tick happened since its last visit and how many ticks it missed while interrupts were masked. At 50 Hz the 8-bit count covers about five seconds. Reads never clear anything. The pending flag is cleared only by its own write access, so a read cannot race a clear. Every access takes effect on the clock edge where the released strobe is first seen high. A read snapshots its value when the strobe falls, and that value stays still for the whole access.

Top module: `tick_irq_gen`

## Requirements
- R1: The prescaler emits one reference strobe every PRESCALE_DIV clock cycles, counting from reset release.
- R2: A tick occurs once every N reference strobes, where N is the reload value and a reload of 0 means 256. The first tick after reset comes PRESCALE_DIV*RELOAD_RST cycles after reset release. A new reload value takes effect when the period in progress ends.
- R3: The tick count goes up by exactly one on each tick, wraps from 255 to 0, and is never changed by any bus access.
- R4: After reset the tick count is 0, the pending flag is clear (irq_n high), rdata is 0 and the reload value is RELOAD_RST.
- R5: A tick sets the pending flag. irq_n stays low until a clear write is accepted.
- R6: A write of any data to address 1 clears the pending flag. A read at any address never clears it.
- R7: When rd_n falls while cs is high, the addressed value is captured for rdata. Address 0 gives the tick count, address 1 gives the pending flag in bit 0, and address 2 gives the reload value. rdata keeps that value until the next read capture.
- R8: A write takes effect on the clock edge at which wr_n is first sampled high after being low with cs high. It uses the address and data sampled in the cycle before that edge. Nothing changes while wr_n is held low.
- R9: If a tick and an accepted clear write fall on the same clock edge, the pending flag stays set.
- R10: A write to address 2 loads the reload value from wdata, and a read at address 2 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data captured at the start of a read |
| irq_n | output | 1 | Level-held interrupt request, active low |

## Verification
The bench builds the block with PRESCALE_DIV = 4 and RELOAD_RST = 5, so a tick comes every 20 cycles instead of every 147456. At that rate the tick count wraps several times, and ticks land inside read and write accesses often enough to exercise the snapshot and the tick-beats-clear rule. Random reload writes include 0, which reaches the 256-strobe period in 1024 cycles. With 8-bit widths kept, the counter wrap and reload edge values are the same as in the default build.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int BUS_W = 8;

    localparam logic [1:0] ADDR_COUNT  = 2'd0;
    localparam logic [1:0] ADDR_CLEAR  = 2'd1;
    localparam logic [1:0] ADDR_RELOAD = 2'd2;

    typedef struct packed {
        logic             rd_fall;
        logic             commit;
        logic [1:0]       addr;
        logic [BUS_W-1:0] data;
    } bus_evt_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int PRESCALE_DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_stb
);
    localparam int PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE_DIV - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        ref_stb = (cnt_q == LAST);
        cnt_d   = ref_stb ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int          RELOAD_W   = 8,
    parameter int unsigned RELOAD_RST = 144
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_stb,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    localparam logic [RELOAD_W-1:0] START = RELOAD_W'(RELOAD_RST - 1);

    logic [RELOAD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = ref_stb && (cnt_q == '0);
        cnt_d = cnt_q;
        if (ref_stb) begin
            // reload of 0 wraps to all ones: a full 2**RELOAD_W period
            cnt_d = (cnt_q == '0) ? reload - 1'b1 : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= START;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tick_bus_if.sv
module tick_bus_if
    import tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output bus_evt_t         evt
);
    typedef struct packed {
        logic             rd_n;
        logic             wr_n;
        logic             cs;
        logic [1:0]       addr;
        logic [BUS_W-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.rd_n = rd_n;
        smp_d.wr_n = wr_n;
        smp_d.cs   = cs;
        smp_d.addr = addr;
        smp_d.data = wdata;

        evt.rd_fall = smp_q.rd_n && !rd_n && cs;
        evt.commit  = !smp_q.wr_n && wr_n && smp_q.cs;
        evt.addr    = evt.commit ? smp_q.addr : addr;
        evt.data    = smp_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q.rd_n <= 1'b1;
            smp_q.wr_n <= 1'b1;
            smp_q.cs   <= 1'b0;
            smp_q.addr <= '0;
            smp_q.data <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
    import tick_pkg::*;
#(
    parameter int          PRESCALE_DIV = 1024,
    parameter int unsigned RELOAD_RST   = 144,
    parameter int          CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq_n
);
    localparam int RELOAD_W = BUS_W;

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic                pend;
        logic [RELOAD_W-1:0] reload;
        logic [BUS_W-1:0]    hold;
    } state_t;

    state_t   st_d, st_q;
    bus_evt_t evt;
    logic     ref_stb;
    logic     tick;
    logic     clr;
    logic     ld_reload;

    tick_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb)
    );

    tick_divider #(.RELOAD_W(RELOAD_W), .RELOAD_RST(RELOAD_RST)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .reload  (st_q.reload),
        .tick    (tick)
    );

    tick_bus_if u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .addr  (addr),
        .wdata (wdata),
        .evt   (evt)
    );

    always_comb begin
        st_d      = st_q;
        clr       = evt.commit && (evt.addr == ADDR_CLEAR);
        ld_reload = evt.commit && (evt.addr == ADDR_RELOAD);

        if (tick) st_d.cnt = st_q.cnt + 1'b1;

        // a tick on the same edge as a clear keeps the request raised
        st_d.pend = tick || (st_q.pend && !clr);

        if (ld_reload) st_d.reload = evt.data;

        if (evt.rd_fall) begin
            unique case (evt.addr)
                ADDR_COUNT:  st_d.hold = BUS_W'(st_q.cnt);
                ADDR_CLEAR:  st_d.hold = BUS_W'(st_q.pend);
                ADDR_RELOAD: st_d.hold = st_q.reload;
                default:     st_d.hold = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.pend   <= 1'b0;
            st_q.reload <= RELOAD_W'(RELOAD_RST);
            st_q.hold   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.hold;
    assign irq_n = !st_q.pend;
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_n,
    input logic             irq_n,
    input logic [7:0]       rdata,
    input logic             ref_stb,
    input logic             tick,
    input logic             clr,
    input logic             commit,
    input logic             rd_fall,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       reload,
    input logic             ld_reload
);
    p_ref_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> !ref_stb);

    p_tick_on_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ref_stb);

    p_tick_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + 1'b1);

    p_cnt_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_tick_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !irq_n);

    p_flag_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr) |=> !irq_n);

    p_hold_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fall |=> $stable(rdata));

    p_no_commit_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !commit);

    p_tick_beats_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr) |=> !irq_n);

    p_reload_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_reload |=> $stable(reload));
endmodule

bind tick_irq_gen tick_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .irq_n     (irq_n),
    .rdata     (rdata),
    .ref_stb   (ref_stb),
    .tick      (tick),
    .clr       (clr),
    .commit    (evt.commit),
    .rd_fall   (evt.rd_fall),
    .cnt       (st_q.cnt),
    .reload    (st_q.reload),
    .ld_reload (ld_reload)
);

// File: tb/tick_irq_gen_bench.sv
module tick_irq_gen_bench;
    localparam int P  = 4;
    localparam int R0 = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    tick_irq_gen #(.PRESCALE_DIV(P), .RELOAD_RST(R0), .CNT_W(8)) u_tick_irq_gen (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    // reference model built from the requirements
    int         m_pre, m_dcnt;
    logic [7:0] m_cnt, m_reload;
    logic       m_pend;
    logic       m_wr_prev, m_cs_prev;
    logic [1:0] m_addr_prev;
    logic [7:0] m_data_prev;
    int         m_edges, m_first_tick;
    bit         m_fire, m_commit;

    function automatic int period_of(logic [7:0] rl);
        return (rl == 8'd0) ? 256 : int'(rl);
    endfunction

    function automatic bit next_is_tick();
        return (m_pre == P - 1) && (m_dcnt == 0);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pre = 0; m_dcnt = R0 - 1; m_cnt = 8'd0; m_pend = 1'b0;
            m_reload = 8'(R0); m_wr_prev = 1'b1; m_cs_prev = 1'b0;
            m_addr_prev = 2'd0; m_data_prev = 8'd0; m_edges = 0; m_first_tick = -1;
        end else begin
            m_edges++;
            m_fire   = next_is_tick();
            m_commit = !m_wr_prev && wr_n && m_cs_prev;
            if (m_pre == P - 1) begin
                m_pre = 0;
                m_dcnt = (m_dcnt == 0) ? period_of(m_reload) - 1 : m_dcnt - 1;
            end else m_pre++;
            if (m_fire) begin
                m_cnt = m_cnt + 8'd1;
                if (m_first_tick < 0) m_first_tick = m_edges;
            end
            m_pend = m_fire || (m_pend && !(m_commit && m_addr_prev == 2'd1));
            if (m_commit && m_addr_prev == 2'd2) m_reload = m_data_prev;
            m_wr_prev = wr_n; m_cs_prev = cs; m_addr_prev = addr; m_data_prev = wdata;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // pending flag seen at the pin every cycle (R5, R6, R9)
    always @(negedge clk) if (rst_n) check("R5", {31'd0, irq_n}, {31'd0, !m_pend});

    task automatic bus_read(logic [1:0] a, int hold_cycles, string req);
        logic [7:0] exp;
        @(negedge clk);
        cs = 1'b1; addr = a; rd_n = 1'b0;
        exp = (a == 2'd0) ? m_cnt : (a == 2'd1) ? {7'd0, m_pend} : m_reload;
        for (int i = 0; i < hold_cycles; i++) begin
            @(negedge clk);
            check(req, rdata, exp);   // R7: stable through the access
        end
        rd_n = 1'b1;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d, int low_cycles);
        @(negedge clk);
        cs = 1'b1; addr = a; wdata = d; wr_n = 1'b0;
        for (int i = 1; i < low_cycles; i++) @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs = 1'b0;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R4 reset state
        check("R4", {31'd0, irq_n}, 32'd1);
        check("R4", rdata, 32'd0);
        rst_n = 1'b1;

        // R2 first tick arrives P*R0 cycles after reset release; R1 spacing
        wait (!irq_n);
        @(negedge clk);
        check("R2", m_first_tick, P * R0);
        check("R1", m_first_tick % P, 0);
        bus_read(2'd2, 1, "R4");                   // default reload
        check("R4", rdata, R0);

        // R6: reads leave the flag raised
        bus_read(2'd0, 2, "R7");
        bus_read(2'd1, 1, "R6");
        check("R6", {31'd0, irq_n}, 32'd0);

        // R8: clear held low across several cycles, flag unchanged while low
        @(negedge clk);
        wait (m_pend && !next_is_tick());
        cs = 1'b1; addr = 2'd1; wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        if (!next_is_tick()) check("R8", {31'd0, irq_n}, 32'd0);
        wr_n = 1'b1;
        @(negedge clk);
        cs = 1'b0;
        check("R6", {31'd0, irq_n}, {31'd0, !m_pend});

        // R9: release the clear write on the very edge a tick fires
        @(negedge clk);
        cs = 1'b1; addr = 2'd1; wr_n = 1'b0;
        @(negedge clk);
        while (!next_is_tick()) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs = 1'b0;
        check("R9", {31'd0, irq_n}, 32'd0);

        // R10 reload write and readback; R2 new period
        bus_write(2'd2, 8'd3, 1);
        bus_read(2'd2, 1, "R10");
        check("R10", rdata, 32'd3);

        // R3: long run through several counter wraps, sampling as we go
        for (int n = 0; n < 40; n++) begin
            repeat (200) @(negedge clk);
            bus_read(2'd0, 1 + ($urandom % 3), "R3");
        end

        // random mix of accesses, reload values including 0 (period 256)
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 4)
                0: bus_read(2'($urandom % 3), 1 + ($urandom % 4), "R7");
                1: bus_write(2'd1, 8'($urandom), 1 + ($urandom % 3));
                2: bus_write(2'd2, (($urandom % 10) == 0) ? 8'd0 : 8'(1 + $urandom % 8),
                             1 + ($urandom % 2));
                default: repeat (1 + $urandom % 30) @(negedge clk);
            endcase
        end
        bus_read(2'd0, 1, "R3");
        bus_read(2'd2, 1, "R10");

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule